// File: doc/BRIEF.md
# Bit Clock and Frame Sync Generator

This block turns a fast reference clock into a serial bit clock by programmable integer division, and then counts bit clocks to build a periodic frame sync pulse. The frame length and the active pulse length are both programmed in bit-clock units, each as a "count minus one" field. A one-cycle strobe marks every rising edge of the bit clock. Downstream shifters use it as their clock enable, so they stay in the reference clock domain.

Two separate run controls start the block in stages. The clock generator must be running before the frame sync can be produced. If frame sync generation is enabled while the generator is stopped, the pulse stays inactive. A polarity input selects whether the frame sync is driven active high or active low. The inactive level follows that input, including while the block is idle.

Top module: `srg_gen`

## Requirements
- R1: While `rst_n` is low, `bit_clk` and `bit_stb` are 0 and `frame_sync` equals `fs_active_low`, which is the inactive level.
- R2: While `gen_enable` is 0, `bit_clk` and `bit_stb` stay 0 from the next reference edge onward, and `frame_sync` stays inactive, whatever the value of `fs_enable`.
- R3: On the first reference edge with `gen_enable` at 1, `bit_stb` goes to 1. After that, `bit_stb` is exactly one reference cycle wide and repeats every `clk_div`+1 reference cycles.
- R4: Counting reference cycles n from the first strobe, `bit_clk` is 1 when n mod (`clk_div`+1) is at most floor(`clk_div`/2), and 0 otherwise. With `clk_div` = 0, the bit clock stays at 1 and the strobe is set on every cycle.
- R5: `frame_sync` stays inactive until `fs_enable` has been seen at 1. The frame then starts on the first bit-clock strobe after that, with the bit and frame counters restarted from zero.
- R6: A frame lasts `frame_len_m1`+1 bit clocks. The frame sync is active during the first `pulse_len_m1`+1 bit clocks of each frame.
- R7: When `pulse_len_m1` is greater than or equal to `frame_len_m1`, the frame sync is active for the whole frame, without a gap.
- R8: `frame_sync` equals the internal active flag XOR `fs_active_low`. A polarity of 0 gives an active-high pulse, and a polarity of 1 gives an active-low pulse.
- R9: Clearing `fs_enable` alone makes `frame_sync` inactive at the next reference edge. The bit clock and the strobe keep running unchanged.
- R10: Clearing `gen_enable`, with or without `fs_enable`, stops `bit_clk`, `bit_stb` and `frame_sync` at the next reference edge.
- R11: Every value of `frame_len_m1` is usable up to 2^PER_W-1. With the default PER_W of 12, that gives frames of 4096 bit clocks.
- R12: Setting `pulse_len_m1` = N-1 and `frame_len_m1` = 2N-1 gives a frame sync with a 50 % duty cycle, N bit clocks active then N inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_enable | input | 1 | Runs the clock generator (0 holds it idle) |
| fs_enable | input | 1 | Runs frame sync generation (effective only while the generator runs) |
| clk_div | input | DIV_W | Divider minus one; bit clock = reference / (clk_div+1) |
| frame_len_m1 | input | PER_W | Bit clocks per frame minus one |
| pulse_len_m1 | input | WID_W | Active frame sync length in bit clocks minus one |
| fs_active_low | input | 1 | Frame sync polarity: 0 active high, 1 active low |
| bit_clk | output | 1 | Divided serial bit clock |
| bit_stb | output | 1 | One-cycle strobe at each bit clock rising edge |
| frame_sync | output | 1 | Periodic frame sync pulse |

## Verification
The bench builds the block with its default field widths: an 8-bit divider, a 12-bit frame length and an 8-bit pulse length. It sweeps divider values 0 to 3 against frame lengths of 1, 2, 4 and 8 bit clocks, pulse lengths both shorter and longer than the frame, and both polarities. That range reaches the divide-by-one case, odd and even high times, pulse lengths that fill the whole frame, and the symmetric pulse. The 12-bit frame field also lets one run cover the 4096-bit-clock frame. Separate runs enable frame sync at different phases of the bit clock, and stop the block in three ways: frame sync only, generator only, or both.

// File: rtl/srg_pkg.sv
package srg_pkg;
   typedef enum logic {
      FR_IDLE = 1'b0,
      FR_RUN  = 1'b1
   } frame_state_e;
endpackage

// File: rtl/srg_bitclk.sv
module srg_bitclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic [DIV_W-1:0] div,
   output logic             bit_clk,
   output logic             bit_stb,
   output logic             stb_next
);
   logic             run_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cnt_d;
   logic [DIV_W-1:0] half_lim;
   logic             clk_d;

   assign half_lim = div >> 1;

   // counter restarts at zero on the first edge after a stopped generator
   always_comb begin
      cnt_d = '0;
      if (run_q && (cnt_q < div))
         cnt_d = cnt_q + 1'b1;
   end

   assign clk_d    = run_req && (cnt_d <= half_lim);
   assign stb_next = run_req && (cnt_d == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         cnt_q   <= '0;
         bit_clk <= 1'b0;
         bit_stb <= 1'b0;
      end else begin
         run_q   <= run_req;
         cnt_q   <= run_req ? cnt_d : '0;
         bit_clk <= clk_d;
         bit_stb <= stb_next;
      end
   end
endmodule

// File: rtl/srg_framer.sv
module srg_framer
   import srg_pkg::*;
#(
   parameter int PER_W = 12,
   parameter int WID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_en,
   input  logic             stb_next,
   input  logic [PER_W-1:0] per,
   input  logic [WID_W-1:0] wid,
   output logic             active
);
   frame_state_e     st_q;
   logic [PER_W-1:0] pos_q;
   logic [PER_W-1:0] pos_n;
   logic             in_pulse;

   assign pos_n = ((st_q == FR_IDLE) || (pos_q >= per)) ? '0 : pos_q + 1'b1;

   generate
      if (WID_W > PER_W) begin : g_wid_wide
         assign in_pulse = (|wid[WID_W-1:PER_W]) || (pos_n <= wid[PER_W-1:0]);
      end else begin : g_wid_narrow
         assign in_pulse = (pos_n <= PER_W'(wid));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FR_IDLE;
         pos_q  <= '0;
         active <= 1'b0;
      end else if (!frame_en) begin
         st_q   <= FR_IDLE;
         pos_q  <= '0;
         active <= 1'b0;
      end else if (stb_next) begin
         st_q   <= FR_RUN;
         pos_q  <= pos_n;
         active <= in_pulse;
      end
   end
endmodule

// File: rtl/srg_gen.sv
module srg_gen #(
   parameter int DIV_W = 8,
   parameter int PER_W = 12,
   parameter int WID_W = 8
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             gen_enable,
   input  logic             fs_enable,
   input  logic [DIV_W-1:0] clk_div,
   input  logic [PER_W-1:0] frame_len_m1,
   input  logic [WID_W-1:0] pulse_len_m1,
   input  logic             fs_active_low,
   output logic             bit_clk,
   output logic             bit_stb,
   output logic             frame_sync
);
   localparam int MAX_FRAME = 1 << PER_W;

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("srg_gen: DIV_W out of range");
      end
      if (PER_W < 2 || MAX_FRAME > 65536) begin : g_bad_per
         $error("srg_gen: PER_W out of range");
      end
      if (WID_W < 1 || WID_W > 16) begin : g_bad_wid
         $error("srg_gen: WID_W out of range");
      end
   endgenerate

   logic stb_next;
   logic fs_act;

   srg_bitclk #(.DIV_W(DIV_W)) u_bitclk (
      .clk      (ref_clk),
      .rst_n    (rst_n),
      .run_req  (gen_enable),
      .div      (clk_div),
      .bit_clk  (bit_clk),
      .bit_stb  (bit_stb),
      .stb_next (stb_next)
   );

   srg_framer #(.PER_W(PER_W), .WID_W(WID_W)) u_framer (
      .clk      (ref_clk),
      .rst_n    (rst_n),
      .frame_en (gen_enable && fs_enable),
      .stb_next (stb_next),
      .per      (frame_len_m1),
      .wid      (pulse_len_m1),
      .active   (fs_act)
   );

   assign frame_sync = fs_act ^ fs_active_low;
endmodule

// File: rtl/srg_gen_chk.sv
module srg_gen_chk #(
   parameter int DIV_W = 8
) (
   input logic             ref_clk,
   input logic             rst_n,
   input logic             gen_enable,
   input logic             fs_enable,
   input logic [DIV_W-1:0] clk_div,
   input logic             fs_active_low,
   input logic             bit_clk,
   input logic             bit_stb,
   input logic             frame_sync
);
   p_idle_quiet_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !gen_enable |=> (!bit_clk && !bit_stb));

   p_strobe_on_high_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      bit_stb |-> bit_clk);

   p_strobe_single_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (bit_stb && gen_enable && (clk_div != '0)) |=> !bit_stb);

   p_fs_off_idle_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !fs_enable |=> (frame_sync == fs_active_low));

   p_fs_needs_gen_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !gen_enable |=> (frame_sync == fs_active_low));

   p_fs_moves_on_strobe_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ($past(gen_enable && fs_enable) && !bit_stb && $stable(fs_active_low))
         |-> $stable(frame_sync));
endmodule

bind srg_gen srg_gen_chk #(.DIV_W(DIV_W)) u_srg_gen_chk (
   .ref_clk       (ref_clk),
   .rst_n         (rst_n),
   .gen_enable    (gen_enable),
   .fs_enable     (fs_enable),
   .clk_div       (clk_div),
   .fs_active_low (fs_active_low),
   .bit_clk       (bit_clk),
   .bit_stb       (bit_stb),
   .frame_sync    (frame_sync)
);

// File: tb/srg_gen_test.sv
module srg_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int PW = 12;
   localparam int WW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          gen_en;
   logic          fs_en;
   logic [DW-1:0] div;
   logic [PW-1:0] per;
   logic [WW-1:0] wid;
   logic          pol;
   logic          bclk;
   logic          stb;
   logic          fsync;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   srg_gen #(.DIV_W(DW), .PER_W(PW), .WID_W(WW)) uut (
      .ref_clk       (clk),
      .rst_n         (rst_n),
      .gen_enable    (gen_en),
      .fs_enable     (fs_en),
      .clk_div       (div),
      .frame_len_m1  (per),
      .pulse_len_m1  (wid),
      .fs_active_low (pol),
      .bit_clk       (bclk),
      .bit_stb       (stb),
      .frame_sync    (fsync)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   // arithmetic reference: n counts reference cycles from the first strobe
   function automatic bit exp_act(int n, int n0, int d, int p, int w, bit on);
      if (!on || n < n0) return 1'b0;
      return (((n - n0) / (d + 1)) % (p + 1)) <= w;
   endfunction

   // s < 0: frame sync enabled together with the generator
   // s >= 0: frame sync enabled after sample s
   // stop_mode 0: clear both, 1: clear frame sync only first, 2: clear generator only
   task automatic run_cfg(int d, int p, int w, bit pl, int s, int nsamp, int stop_mode);
      int    n0;
      string ftag;
      bit    fs_on;
      n0 = (s < 0) ? 0 : ((s + 1 + d) / (d + 1)) * (d + 1);
      if (s >= 0)                ftag = "R5";
      else if (p == 4095)        ftag = "R11";
      else if (w >= p)           ftag = "R7";
      else if (w == 3 && p == 7) ftag = "R12";
      else if (pl)               ftag = "R8";
      else                       ftag = "R6";
      @(negedge clk);
      div = DW'(d); per = PW'(p); wid = WW'(w); pol = pl;
      gen_en = 1'b0; fs_en = (s < 0);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         chk("R2", "idle bit_clk", int'(bclk), 0);
         chk("R2", "idle bit_stb", int'(stb), 0);
         chk("R2", "idle frame_sync", int'(fsync), int'(pl));
      end
      gen_en = 1'b1;
      fs_on = (s < 0);
      for (int n = 0; n < nsamp; n++) begin
         @(negedge clk);
         chk("R4", "bit_clk", int'(bclk), int'((n % (d + 1)) <= d / 2));
         chk("R3", "bit_stb", int'(stb), int'((n % (d + 1)) == 0));
         chk(ftag, "frame_sync", int'(fsync),
             int'(exp_act(n, n0, d, p, w, fs_on) ^ pl));
         if (n == s) begin
            fs_en = 1'b1;
            fs_on = 1'b1;
         end
      end
      if (stop_mode == 1) begin
         fs_en = 1'b0;
         for (int n = nsamp; n < nsamp + 2 * (d + 1); n++) begin
            @(negedge clk);
            chk("R9", "bit_clk runs on", int'(bclk), int'((n % (d + 1)) <= d / 2));
            chk("R9", "bit_stb runs on", int'(stb), int'((n % (d + 1)) == 0));
            chk("R9", "frame_sync off", int'(fsync), int'(pl));
         end
         gen_en = 1'b0;
      end else if (stop_mode == 2) begin
         gen_en = 1'b0;
      end else begin
         gen_en = 1'b0;
         fs_en  = 1'b0;
      end
      @(negedge clk);
      chk("R10", "stopped bit_clk", int'(bclk), 0);
      chk("R10", "stopped bit_stb", int'(stb), 0);
      chk("R10", "stopped frame_sync", int'(fsync), int'(pl));
      fs_en = 1'b0;
   endtask

   initial begin
      int ps[4];
      int ws[4];
      ps = '{0, 1, 3, 7};
      ws = '{0, 1, 3, 8};
      rst_n = 1'b0; gen_en = 1'b0; fs_en = 1'b0;
      div = '0; per = '0; wid = '0; pol = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "reset bit_clk", int'(bclk), 0);
      chk("R1", "reset bit_stb", int'(stb), 0);
      chk("R1", "reset frame_sync low-active", int'(fsync), 1);
      gen_en = 1'b1; fs_en = 1'b1; pol = 1'b0;
      @(negedge clk);
      chk("R1", "reset holds bit_clk", int'(bclk), 0);
      chk("R1", "reset frame_sync high-active", int'(fsync), 0);
      gen_en = 1'b0; fs_en = 1'b0;
      rst_n = 1'b1;

      for (int d = 0; d < 4; d++)
         for (int pi = 0; pi < 4; pi++)
            for (int wi = 0; wi < 4; wi++)
               for (int pl = 0; pl < 2; pl++)
                  run_cfg(d, ps[pi], ws[wi], pl[0], -1,
                          (d + 1) * (ps[pi] + 1) * 2 + 3, (d + pi + wi) % 3);

      // staged enable at several bit clock phases
      run_cfg(2, 3, 1, 1'b0, 4, 40, 0);
      run_cfg(1, 2, 0, 1'b1, 0, 30, 1);
      run_cfg(3, 1, 0, 1'b0, 6, 30, 2);
      run_cfg(0, 2, 1, 1'b0, 3, 20, 0);
      run_cfg(3, 3, 1, 1'b1, 11, 50, 1);

      // full-range frame length
      run_cfg(0, 4095, 1, 1'b0, -1, 8200, 0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R3 watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule